// File: doc/BRIEF.md
# External Interrupt Edge Conditioner

This block turns three kinds of external event inputs into sticky request flags for a small controller core. A primary pin passes through a two-stage synchroniser and a pulse-width qualifier whose length is chosen by a mode field. It raises a request only when the qualified level changes in the selected direction. A secondary pin is captured by two flops with no qualification, so a change that lasts one clock still counts. A four-bit key group raises one shared request whenever any of its lines goes from high to low.

Software configures the block through a single mode-write port. That port sets the active edge of each pin and the qualifier length. Software reads the three pending flags and clears them by pulsing the matching bit of a clear input. A request that arrives in the same clock as its clear is kept, so no event is lost.

Top module: `extint_conditioner`

## Requirements
- R1: While `rst` is high at a clock edge, all `pend` bits become 0 and the mode becomes falling edge on both pins with the short qualifier. Inputs are assumed idle high.
- R2: A clock edge with `mode_we` high loads `mode_wdata` into the mode, and the new mode governs events from the next edge onward. Bit 0 selects the primary pin edge and bit 1 the secondary pin edge, with 1 meaning rising and 0 meaning falling. Bit 2 set selects the long qualifier.
- R3: The primary pin sets `pend[0]` when its synchronised level differs from the accepted level on FILT_SHORT consecutive clocks in the selected direction. A level presented before clock edge 1 and held for exactly FILT_SHORT edges sets the flag at edge FILT_SHORT+2.
- R4: A primary-pin excursion shorter than the active qualifier length sets no request. An accepted change in the unselected direction also sets no request.
- R5: The secondary pin sets `pend[1]` at the second clock edge after a change in the selected direction, even for a one-clock pulse. Changes in the other direction are ignored.
- R6: `pend[2]` is set at the second clock edge after any `keys` bit falls. Rising key lines set nothing.
- R7: A set `pend` bit stays set until a clock edge where the same-index bit of `pend_clr` is high. Bit 0 is the primary pin, bit 1 the secondary pin and bit 2 the key group.
- R8: When a set event and a clear of the same flag fall on the same clock edge, the flag is 1 afterwards.
- R9: With mode bit 2 set, the primary pin needs FILT_LONG consecutive differing clocks. A hold of FILT_LONG edges sets the flag at edge FILT_LONG+2, and a 60-clock hold sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Primary event pin, synchronised and qualified |
| pin_b | input | 1 | Secondary event pin, unqualified |
| keys | input | KEY_W | Key group lines, falling edge active |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Mode value {long qualifier, secondary edge, primary edge} |
| pend_clr | input | 3 | Write-one-to-clear strobes for the pending flags |
| pend | output | 3 | Pending flags {key group, secondary, primary} |

## Verification
The primary pin is driven with excursions of exactly the qualifier length and of one clock less, under both the short and the long setting. These patterns place the acceptance boundary and expose an off-by-one in the qualifier count. Single-clock pulses on the secondary pin show that it has no filter. Driving both directions under each edge mode shows that the unselected direction is dropped. Single and simultaneous key falls, followed by key releases, tell the falling-only rule apart from plain change detection. A clear placed on the same edge as a new event shows which of the two wins.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic      filt_long;
        edge_sel_e edge_b;
        edge_sel_e edge_a;
    } mode_t;

    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;
    localparam int SRC_KEY = 2;
    localparam int NUM_SRC = 3;

    function automatic logic edge_hit(input logic prev, input logic cur, input edge_sel_e sel);
        return (sel == EDGE_RISE) ? (~prev & cur) : (prev & ~cur);
    endfunction

endpackage

// File: rtl/extint_qual_path.sv
module extint_qual_path
    import extint_pkg::*;
#(
    parameter int FILT_SHORT = 4,
    parameter int FILT_LONG  = 128
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  logic      use_long,
    input  edge_sel_e sel,
    output logic      evt
);
    localparam int CW = $clog2(FILT_LONG + 1);
    localparam logic [CW-1:0] LEN_S = CW'(FILT_SHORT);
    localparam logic [CW-1:0] LEN_L = CW'(FILT_LONG);

    logic [1:0]    sync_q;
    logic          lvl_q;
    logic [CW-1:0] run_q;
    logic [CW-1:0] len_cur;
    logic          s_lvl;
    logic          accept;

    assign s_lvl   = sync_q[1];
    assign len_cur = use_long ? LEN_L : LEN_S;
    assign accept  = (s_lvl != lvl_q) && (run_q >= len_cur - CW'(1));
    assign evt     = accept && edge_hit(lvl_q, s_lvl, sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= 1'b1;
            run_q <= '0;
        end else if (s_lvl == lvl_q) begin
            run_q <= '0;
        end else if (accept) begin
            lvl_q <= s_lvl;
            run_q <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end

    // accepted level may only move to a value the synchroniser already held
    AST_LVL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> ($past(s_lvl) == lvl_q)); // R4

endmodule

// File: rtl/extint_raw_edge.sv
module extint_raw_edge
    import extint_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    logic [W-1:0] cap1_q;
    logic [W-1:0] cap2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap1_q <= '1;
            cap2_q <= '1;
        end else begin
            cap1_q <= din;
            cap2_q <= cap1_q;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign hit[i] = edge_hit(cap2_q[i], cap1_q[i], edge_sel_e'(rise_sel[i]));
    end

endmodule

// File: rtl/extint_pend_bit.sv
module extint_pend_bit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= (flag & ~clr) | set;
        end
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set && clr) |=> flag); // R8

endmodule

// File: rtl/extint_conditioner.sv
module extint_conditioner
    import extint_pkg::*;
#(
    parameter int FILT_SHORT = 4,
    parameter int FILT_LONG  = 128,
    parameter int KEY_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic [KEY_W-1:0] keys,
    input  logic             mode_we,
    input  logic [2:0]       mode_wdata,
    input  logic [2:0]       pend_clr,
    output logic [2:0]       pend
);
    mode_t              mode_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [KEY_W-1:0]   key_hit;
    logic [0:0]         b_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{filt_long: 1'b0, edge_b: EDGE_FALL, edge_a: EDGE_FALL};
        end else if (mode_we) begin
            mode_q <= mode_t'(mode_wdata);
        end
    end

    extint_qual_path #(
        .FILT_SHORT(FILT_SHORT),
        .FILT_LONG (FILT_LONG)
    ) u_qual_a (
        .clk     (clk),
        .rst     (rst),
        .pin     (pin_a),
        .use_long(mode_q.filt_long),
        .sel     (mode_q.edge_a),
        .evt     (set_vec[SRC_A])
    );

    extint_raw_edge #(.W(1)) u_edge_b (
        .clk     (clk),
        .rst     (rst),
        .din     (pin_b),
        .rise_sel(mode_q.edge_b),
        .hit     (b_hit)
    );
    assign set_vec[SRC_B] = b_hit[0];

    extint_raw_edge #(.W(KEY_W)) u_edge_key (
        .clk     (clk),
        .rst     (rst),
        .din     (keys),
        .rise_sel({KEY_W{1'b0}}),
        .hit     (key_hit)
    );
    assign set_vec[SRC_KEY] = |key_hit;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_pend
        extint_pend_bit u_pend (
            .clk (clk),
            .rst (rst),
            .set (set_vec[s]),
            .clr (pend_clr[s]),
            .flag(pend[s])
        );
    end

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
        mode_we |=> (mode_q == $past(mode_wdata))); // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mode_we |=> $stable(mode_q)); // R2

endmodule

// File: tb/extint_conditioner_bench.sv
module extint_conditioner_bench;
    localparam int SHORT = 4;
    localparam int LONG  = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_a = 1'b1;
    logic       pin_b = 1'b1;
    logic [3:0] keys = 4'hF;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic [2:0] pend_clr = 3'b000;
    logic [2:0] pend;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    extint_conditioner #(.FILT_SHORT(SHORT), .FILT_LONG(LONG), .KEY_W(4)) u_extint_conditioner (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b), .keys(keys),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .pend_clr(pend_clr), .pend(pend)
    );

    // behavioural reference: input sample history and run length per clock
    logic       a_hist[$];
    logic       b_prev1, b_prev2;
    logic [3:0] k_prev1, k_prev2;
    logic       a_acc;
    int         a_run;
    logic [2:0] m_mode;
    logic [2:0] m_pend;

    always @(posedge clk) begin
        logic [2:0] set;
        logic       a_old;
        int         need;
        set = 3'b000;
        if (rst) begin
            a_hist = {1'b1, 1'b1};
            b_prev1 = 1'b1; b_prev2 = 1'b1;
            k_prev1 = 4'hF; k_prev2 = 4'hF;
            a_acc = 1'b1; a_run = 0;
            m_mode = 3'b000; m_pend = 3'b000;
        end else begin
            a_old = a_hist[0];
            need  = m_mode[2] ? LONG : SHORT;
            if (a_old != a_acc) begin
                a_run++;
                if (a_run >= need) begin
                    set[0] = m_mode[0] ? (a_old == 1'b1) : (a_old == 1'b0);
                    a_acc = a_old;
                    a_run = 0;
                end
            end else begin
                a_run = 0;
            end
            void'(a_hist.pop_front());
            a_hist.push_back(pin_a);
            set[1] = m_mode[1] ? (!b_prev2 && b_prev1) : (b_prev2 && !b_prev1);
            set[2] = |(k_prev2 & ~k_prev1);
            b_prev2 = b_prev1; b_prev1 = pin_b;
            k_prev2 = k_prev1; k_prev1 = keys;
            m_pend = (m_pend & ~pend_clr) | set;
            if (mode_we) m_mode = mode_wdata;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 3; i++) begin
                n_tests++;
                if (pend[i] !== m_pend[i]) begin
                    n_fail++;
                    $display("FAIL %s per-cycle pend[%0d] actual=%b expected=%b",
                             (i == 0) ? "R3" : ((i == 1) ? "R5" : "R6"), i, pend[i], m_pend[i]);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] v);
        mode_we = 1'b1; mode_wdata = v;
        step(1);
        mode_we = 1'b0;
    endtask

    task automatic clear(input logic [2:0] v);
        pend_clr = v;
        step(1);
        pend_clr = 3'b000;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        chk("R1 reset flags", pend, 3'b000);
        step(2);

        // R3: exactly SHORT clocks low, falling mode from reset
        pin_a = 1'b0; step(SHORT); pin_a = 1'b1;
        step(1); chk("R3 one edge before acceptance", pend, 3'b000);
        step(1); chk("R3 accepted fall", pend, 3'b001);
        step(10); chk("R7 sticky, rising ignored", pend, 3'b001);
        clear(3'b001); chk("R7 cleared", pend, 3'b000);

        // R4: one clock short of the qualifier
        pin_a = 1'b0; step(SHORT - 1); pin_a = 1'b1;
        step(10); chk("R4 short glitch dropped", pend, 3'b000);

        // R2: primary pin on rising edge
        set_mode(3'b001);
        pin_a = 1'b0; step(8); chk("R2 fall ignored in rising mode", pend, 3'b000);
        pin_a = 1'b1; step(8); chk("R2 rising accepted", pend, 3'b001);
        clear(3'b001);

        // R5: one-clock pulse on secondary pin, falling mode
        pin_b = 1'b0; step(1); pin_b = 1'b1; step(1);
        chk("R5 single-clock pulse seen", pend, 3'b010);
        step(3); clear(3'b010); chk("R7 secondary cleared", pend, 3'b000);

        // R5: secondary pin rising mode
        set_mode(3'b011);
        pin_b = 1'b0; step(4); chk("R5 fall ignored in rising mode", pend, 3'b000);
        pin_b = 1'b1; step(1); chk("R5 not before second edge", pend, 3'b000);
        step(1); chk("R5 rising seen", pend, 3'b010);
        clear(3'b010);

        // R6: key group
        keys = 4'b1011; step(2); chk("R6 single key fall", pend, 3'b100);
        clear(3'b100);
        keys = 4'b1111; step(4); chk("R6 key rise ignored", pend, 3'b000);
        keys = 4'b0101; step(3); chk("R6 two keys fall", pend, 3'b100);
        clear(3'b100);
        keys = 4'b1111; step(3); chk("R6 release ignored", pend, 3'b000);

        // R8: clear and new event on the same edge
        pin_b = 1'b0; step(3); pin_b = 1'b1; step(2);
        chk("R5 first rise sets flag", pend, 3'b010);
        pin_b = 1'b0; step(2); pin_b = 1'b1; step(1);
        pend_clr = 3'b010; step(1); pend_clr = 3'b000;
        chk("R8 set wins over clear", pend, 3'b010);
        clear(3'b010); chk("R7 cleared after collision", pend, 3'b000);

        // R9: long qualifier
        set_mode(3'b100);
        pin_a = 1'b0; step(60); pin_a = 1'b1;
        step(140); chk("R9 60-clock hold dropped", pend, 3'b000);
        pin_a = 1'b0; step(LONG); pin_a = 1'b1;
        step(1); chk("R9 one edge before acceptance", pend, 3'b000);
        step(1); chk("R9 long hold accepted", pend, 3'b001);
        clear(3'b001);
        step(5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule